// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block sits beside a small 8-bit processor core. It collects fifteen interrupt sources and picks one at a time. The sources are a reset strobe, four external pins with a selectable edge, a key-matrix port, seven on-chip peripheral event pulses, one shared slot fed by either the converter-done event or an alternate event, and a software break strobe. Each maskable source owns a request latch and an enable bit. Requests are set by hardware events. Software may clear a request latch but can never set one.

When a source is eligible, the controller runs a short handshake with the core. First it pulses `push_stb` so the core saves its program counter and status register. Next it pulses `set_iflag` so the core raises its global disable flag, and in that same cycle it clears the winner's request latch. Finally it holds `vec_valid` together with the winner's vector address until the core returns `ack`. A three-register write/read port gives software access to the enables, the request clears and the edge and source-select configuration.

The control state machine has four states. ST_IDLE goes to ST_PUSH when any source is eligible, and it latches the winner in that transition. ST_PUSH goes unconditionally to ST_MASK. ST_MASK goes unconditionally to ST_GRANT. ST_GRANT stays in place while `ack` is low and returns to ST_IDLE on `ack`.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the enable, request and configuration registers all read 0, and `push_stb`, `set_iflag` and `vec_valid` are all 0.
- R2: Source index i runs from 0 to 14 in priority order, 0 highest: 0 reset, 1 ext pin 0, 2 ext pin 1, 3 serial receive, 4 serial transmit, 5 timer X, 6 timer Y, 7 timer 2, 8 timer 3, 9 ext pin 2, 10 ext pin 1-of-counter (ext pin 3), 11 timer 1, 12 key port, 13 shared slot, 14 break. The eligible source with the lowest index wins. Its vector is 0xFFFC−2i for i≤11 and 0xFFE0−2(i−12) for i≥12.
- R3: A maskable source (index 1 to 13) is accepted only when its request bit is 1, its enable bit is 1 and the `iflag` input is 0.
- R4: Register address 0 holds the enables, with bit i belonging to source i. Only bits 1 to 13 are writable, and the other bits read 0. At address 1, a write of 0 to bit i clears request i, and a write of 1 leaves it unchanged. A read of address 1 returns the requests in bits 0 to 14.
- R5: If a hardware set and a software clear of the same request fall in the same cycle, the request ends up set.
- R6: The reset strobe (index 0) and the break strobe (index 14) are accepted whatever `iflag` and the enables hold. Reset wins over every other source, and break loses to every other source.
- R7: An acceptance gives exactly one `push_stb` cycle, followed at once by one `set_iflag` cycle, followed by `vec_valid`. The winner's request bit is clear after the acceptance. `vec_valid` and `vec_addr` stay steady until `ack` is seen, and `vec_valid` drops in the cycle after that.
- R8: Configuration bits 0 to 3 at address 2 select the edge for ext pins 0 to 3: 0 means rising and 1 means falling. Each pin passes through a two-flop synchronizer before edge detection, and a pin transition on the selected edge sets that pin's request.
- R9: The key source sets its request when the AND of all synchronized key-port bits falls from 1 to 0. A rising AND does nothing.
- R10: Changing a pin's edge-select bit while the pin level makes the new selected sense active sets that pin's request, as if an edge had occurred.
- R11: Configuration bit 4 selects the shared slot's event: 0 for `adc_evt`, 1 for `alt_evt`. The event that is not selected is ignored. Any write that changes bit 4 sets request 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 4 | External edge-triggered pins (asynchronous) |
| key_pin | input | KEY_W | Key port levels (asynchronous) |
| periph_evt | input | 7 | Peripheral event pulses, in the order of indexes 3,4,5,6,7,8,11 |
| adc_evt | input | 1 | Converter-done pulse for the shared slot |
| alt_evt | input | 1 | Alternate pulse for the shared slot |
| rst_src | input | 1 | Reset-source strobe |
| brk_src | input | 1 | Break-instruction strobe |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for `cfg_addr` |
| iflag | input | 1 | Core's global interrupt-disable flag |
| ack | input | 1 | Core accepts the presented vector |
| push_stb | output | 1 | Save PC and status now |
| set_iflag | output | 1 | Raise the disable flag now |
| vec_valid | output | 1 | Vector address is valid |
| vec_addr | output | 16 | Low-byte address of the winner's vector |

## Verification
A wrong latched winner shows up within three cycles of acceptance as a wrong `vec_addr`, and the bench compares it against a vector table of its own. A request latch stuck at 1 shows at once on a read of address 1. It also shows as a repeated grant on the next unmask. A latch that never sets shows as a missing `push_stb` inside the bench's wait window. A state machine that skips or repeats a phase breaks the one-cycle spacing of `push_stb`, `set_iflag` and `vec_valid`, and this is visible in the very cycle where it happens.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_SRC = 15;
    localparam int IDX_W   = 4;
    localparam int REG_W   = 16;
    localparam int NUM_EXT = 4;
    localparam int NUM_PER = 7;

    typedef logic [IDX_W-1:0] src_idx_t;

    localparam src_idx_t SRC_RESET  = 4'd0;
    localparam src_idx_t SRC_KEY    = 4'd12;
    localparam src_idx_t SRC_SHARED = 4'd13;
    localparam src_idx_t SRC_BRK    = 4'd14;

    // indexes 1..13 are subject to enable bits and the disable flag
    localparam logic [NUM_SRC-1:0] MASKABLE = 15'b011_1111_1111_1110;

    localparam src_idx_t EXT_SLOT [NUM_EXT] = '{4'd1, 4'd2, 4'd9, 4'd10};
    localparam src_idx_t PER_SLOT [NUM_PER] = '{4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd11};

    localparam logic [1:0] RA_ENABLE  = 2'd0;
    localparam logic [1:0] RA_REQUEST = 2'd1;
    localparam logic [1:0] RA_CONFIG  = 2'd2;

    typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_MASK, ST_GRANT} irq_state_e;

    // vector table has a six-byte hole between index 11 and index 12
    function automatic logic [15:0] vector_of(input src_idx_t idx);
        if (idx <= 4'd11)
            return 16'hFFFC - {11'd0, idx, 1'b0};
        else
            return 16'hFFE0 - {11'd0, idx - 4'd12, 1'b0};
    endfunction
endpackage

// File: rtl/irq_edge_front.sv
module irq_edge_front
    import irq_pkg::*;
#(
    parameter int KEY_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXT-1:0] ext_pin,
    input  logic [NUM_EXT-1:0] fall_sel,
    input  logic [KEY_W-1:0]   key_pin,
    input  logic [NUM_PER-1:0] periph_evt,
    input  logic               adc_evt,
    input  logic               alt_evt,
    input  logic               shared_sel,
    input  logic               rst_src,
    input  logic               brk_src,
    output logic [NUM_SRC-1:0] set_evt
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0][NUM_EXT-1:0] ext_sync;
    logic [SYNC_STAGES-1:0][KEY_W-1:0]   key_sync;
    logic [NUM_EXT-1:0] sense, sense_q, ext_rise;
    logic               key_all, key_all_q, key_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_sync <= '0;
            key_sync <= '0;
        end else begin
            ext_sync[0] <= ext_pin;
            key_sync[0] <= key_pin;
            for (int s = 1; s < SYNC_STAGES; s++) begin
                ext_sync[s] <= ext_sync[s-1];
                key_sync[s] <= key_sync[s-1];
            end
        end
    end

    // polarity folded into the level: flipping fall_sel can itself make a rise
    assign sense   = ext_sync[LAST] ^ fall_sel;
    assign key_all = &key_sync[LAST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense_q   <= '0;
            key_all_q <= 1'b0;
        end else begin
            sense_q   <= sense;
            key_all_q <= key_all;
        end
    end

    assign ext_rise = sense & ~sense_q;
    assign key_fall = key_all_q & ~key_all;

    always_comb begin
        set_evt             = '0;
        set_evt[SRC_RESET]  = rst_src;
        set_evt[SRC_BRK]    = brk_src;
        set_evt[SRC_KEY]    = key_fall;
        set_evt[SRC_SHARED] = shared_sel ? alt_evt : adc_evt;
        for (int k = 0; k < NUM_EXT; k++) set_evt[EXT_SLOT[k]] = ext_rise[k];
        for (int p = 0; p < NUM_PER; p++) set_evt[PER_SLOT[p]] = periph_evt[p];
    end
endmodule

// File: rtl/irq_req_bank.sv
module irq_req_bank
    import irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         addr,
    input  logic [REG_W-1:0]   wdata,
    input  logic [NUM_SRC-1:0] set_evt,
    input  logic               acc_clr_en,
    input  src_idx_t           acc_idx,
    output logic [NUM_SRC-1:0] req,
    output logic [NUM_SRC-1:0] en,
    output logic [NUM_EXT-1:0] fall_sel,
    output logic               shared_sel,
    output logic [REG_W-1:0]   rdata
);
    logic [NUM_SRC-1:0] req_q, en_q, sw_clr, acc_clr, set_all;
    logic [NUM_EXT:0]   cfg_q;
    logic               sel_flip;

    assign sel_flip = wr_en && (addr == RA_CONFIG) && (wdata[NUM_EXT] != cfg_q[NUM_EXT]);
    assign sw_clr   = (wr_en && addr == RA_REQUEST) ? (~wdata[NUM_SRC-1:0] & MASKABLE) : '0;
    assign acc_clr  = acc_clr_en ? (NUM_SRC'(1) << acc_idx) : '0;
    assign set_all  = set_evt | (NUM_SRC'(sel_flip) << SRC_SHARED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
            en_q  <= '0;
            cfg_q <= '0;
        end else begin
            req_q <= (req_q & ~(sw_clr | acc_clr)) | set_all;   // set wins
            if (wr_en && addr == RA_ENABLE) en_q  <= wdata[NUM_SRC-1:0] & MASKABLE;
            if (wr_en && addr == RA_CONFIG) cfg_q <= wdata[NUM_EXT:0];
        end
    end

    always_comb begin
        unique case (addr)
            RA_ENABLE:  rdata = REG_W'(en_q);
            RA_REQUEST: rdata = REG_W'(req_q);
            RA_CONFIG:  rdata = REG_W'(cfg_q);
            default:    rdata = '0;
        endcase
    end

    assign req        = req_q;
    assign en         = en_q;
    assign fall_sel   = cfg_q[NUM_EXT-1:0];
    assign shared_sel = cfg_q[NUM_EXT];
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] req,
    input  logic [NUM_SRC-1:0] en,
    input  logic               iflag,
    output logic               any,
    output src_idx_t           idx
);
    logic [NUM_SRC-1:0] eligible;

    assign eligible = req & ((en & {NUM_SRC{~iflag}}) | ~MASKABLE);
    assign any      = |eligible;

    always_comb begin
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--)
            if (eligible[i]) idx = src_idx_t'(i);
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_pkg::*;
#(
    parameter int KEY_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXT-1:0] ext_pin,
    input  logic [KEY_W-1:0]   key_pin,
    input  logic [NUM_PER-1:0] periph_evt,
    input  logic               adc_evt,
    input  logic               alt_evt,
    input  logic               rst_src,
    input  logic               brk_src,
    input  logic               cfg_wr,
    input  logic [1:0]         cfg_addr,
    input  logic [REG_W-1:0]   cfg_wdata,
    output logic [REG_W-1:0]   cfg_rdata,
    input  logic               iflag,
    input  logic               ack,
    output logic               push_stb,
    output logic               set_iflag,
    output logic               vec_valid,
    output logic [15:0]        vec_addr
);
    irq_state_e         state_q, state_d;
    src_idx_t           win_q, pick_idx;
    logic               pick_any, acc_clr_en, shared_sel;
    logic [NUM_SRC-1:0] set_evt, req, en;
    logic [NUM_EXT-1:0] fall_sel;

    irq_edge_front #(.KEY_W(KEY_W), .SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .fall_sel(fall_sel),
        .key_pin(key_pin), .periph_evt(periph_evt), .adc_evt(adc_evt),
        .alt_evt(alt_evt), .shared_sel(shared_sel), .rst_src(rst_src),
        .brk_src(brk_src), .set_evt(set_evt)
    );

    irq_req_bank u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .addr(cfg_addr),
        .wdata(cfg_wdata), .set_evt(set_evt), .acc_clr_en(acc_clr_en),
        .acc_idx(win_q), .req(req), .en(en), .fall_sel(fall_sel),
        .shared_sel(shared_sel), .rdata(cfg_rdata)
    );

    irq_prio_pick u_pick (
        .req(req), .en(en), .iflag(iflag), .any(pick_any), .idx(pick_idx)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            win_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && pick_any) win_q <= pick_idx;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (pick_any) state_d = ST_PUSH;
            ST_PUSH:  state_d = ST_MASK;
            ST_MASK:  state_d = ST_GRANT;
            ST_GRANT: if (ack) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        push_stb   = 1'b0;
        set_iflag  = 1'b0;
        vec_valid  = 1'b0;
        acc_clr_en = 1'b0;
        vec_addr   = '0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_PUSH:  push_stb = 1'b1;
            ST_MASK: begin
                set_iflag  = 1'b1;
                acc_clr_en = 1'b1;
            end
            ST_GRANT: begin
                vec_valid = 1'b1;
                vec_addr  = vector_of(win_q);
            end
            default:  ;
        endcase
    end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        push_stb,
    input logic        set_iflag,
    input logic        vec_valid,
    input logic [15:0] vec_addr,
    input logic        ack
);
    // R7
    push_then_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_stb |=> set_iflag);
    // R7
    mask_then_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_iflag |=> vec_valid);
    // R7
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !ack) |=> (vec_valid && $stable(vec_addr)));
    // R7
    grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && ack) |=> !vec_valid);
    // R7
    single_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({push_stb, set_iflag, vec_valid}));
    // R2
    vector_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_addr[0] == 1'b0 && vec_addr >= 16'hFFDC));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk i_chk (
    .clk(clk), .rst_n(rst_n), .push_stb(push_stb), .set_iflag(set_iflag),
    .vec_valid(vec_valid), .vec_addr(vec_addr), .ack(ack)
);

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
    localparam int KEY_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0]       ext_pin = '0;
    logic [KEY_W-1:0] key_pin = '1;
    logic [6:0]       periph_evt = '0;
    logic adc_evt = 0, alt_evt = 0, rst_src = 0, brk_src = 0;
    logic cfg_wr = 0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic iflag = 1'b1, ack = 1'b0;
    logic push_stb, set_iflag, vec_valid;
    logic [15:0] vec_addr;

    int checks = 0, errors = 0;
    bit done = 0;

    irq_vector_ctrl #(.KEY_W(KEY_W)) i_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .key_pin(key_pin),
        .periph_evt(periph_evt), .adc_evt(adc_evt), .alt_evt(alt_evt),
        .rst_src(rst_src), .brk_src(brk_src), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .iflag(iflag), .ack(ack), .push_stb(push_stb), .set_iflag(set_iflag),
        .vec_valid(vec_valid), .vec_addr(vec_addr)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic pulse_per(input int b);
        @(negedge clk); periph_evt[b] = 1'b1;
        @(negedge clk); periph_evt[b] = 1'b0;
    endtask

    task automatic take(input string tag, input logic [15:0] exp, input bit unmask);
        int push_c = -1, mask_c = -1, grant_c = -1;
        if (unmask) iflag = 1'b0;
        for (int n = 0; n < 40 && grant_c < 0; n++) begin
            @(negedge clk);
            if (push_stb && push_c < 0) push_c = n;
            if (set_iflag && mask_c < 0) mask_c = n;
            if (vec_valid) grant_c = n;
        end
        iflag = 1'b1;
        check({tag, " vector"}, vec_addr, exp);
        check({tag, " R7 phase order"}, (push_c >= 0 && mask_c == push_c + 1 && grant_c == mask_c + 1), 1);
        @(negedge clk);
        check({tag, " R7 hold"}, {vec_valid, vec_addr}, {1'b1, exp});
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        check({tag, " R7 release"}, vec_valid, 0);
    endtask

    task automatic expect_none(input string tag, input int cycles);
        int seen = 0;
        for (int n = 0; n < cycles; n++) begin
            @(negedge clk);
            if (push_stb || vec_valid) seen++;
        end
        check(tag, seen, 0);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        check("R1 outputs idle", {push_stb, set_iflag, vec_valid}, 0);
        rd(2'd0, d); check("R1 enable reg", d, 0);
        rd(2'd1, d); check("R1 request reg", d, 0);
        rd(2'd2, d); check("R1 config reg", d, 0);
    endtask

    task automatic t_sw_access();
        logic [15:0] d;
        wr(2'd0, 16'hFFFF);
        rd(2'd0, d); check("R4 enable writable bits", d, 16'h3FFE);
        pulse_per(0); pulse_per(6);
        rd(2'd1, d); check("R4 requests set by events", d, 16'h0808);
        wr(2'd1, 16'hFFFF);
        rd(2'd1, d); check("R4 write of ones has no effect", d, 16'h0808);
        wr(2'd1, 16'hFFF7);
        rd(2'd1, d); check("R4 zero clears one bit", d, 16'h0800);
        wr(2'd1, 16'h0000);
        rd(2'd1, d); check("R4 clear all", d, 16'h0000);
    endtask

    task automatic t_set_wins();
        logic [15:0] d;
        @(negedge clk);
        periph_evt[0] = 1'b1; cfg_wr = 1'b1; cfg_addr = 2'd1; cfg_wdata = 16'h0000;
        @(negedge clk);
        periph_evt[0] = 1'b0; cfg_wr = 1'b0;
        rd(2'd1, d); check("R5 set beats clear", d, 16'h0008);
        wr(2'd1, 16'h0000);
    endtask

    task automatic t_mask();
        logic [15:0] d;
        wr(2'd0, 16'h0000);
        pulse_per(4);
        iflag = 1'b0;
        expect_none("R3 disabled source ignored", 12);
        iflag = 1'b1;
        wr(2'd0, 16'h0080);
        expect_none("R3 disable flag blocks", 12);
        take("R3 enabled and unmasked", 16'hFFEE, 1);
        rd(2'd1, d); check("R7 request cleared on accept", d, 0);
    endtask

    task automatic t_priority();
        wr(2'd0, 16'hFFFF);
        pulse_per(6); pulse_per(4); pulse_per(1);
        @(negedge clk); adc_evt = 1'b1; @(negedge clk); adc_evt = 1'b0;
        take("R2 serial tx first", 16'hFFF4, 1);
        take("R2 timer 2 next", 16'hFFEE, 1);
        take("R2 timer 1 past gap", 16'hFFE6, 1);
        take("R2 shared slot", 16'hFFDE, 1);
    endtask

    task automatic t_unmaskable();
        wr(2'd0, 16'h0000);
        @(negedge clk); brk_src = 1'b1; @(negedge clk); brk_src = 1'b0;
        take("R6 break under disable", 16'hFFDC, 0);
        @(negedge clk); brk_src = 1'b1; rst_src = 1'b1;
        @(negedge clk); brk_src = 1'b0; rst_src = 1'b0;
        take("R6 reset wins", 16'hFFFC, 0);
        take("R6 break after reset", 16'hFFDC, 0);
    endtask

    task automatic t_edges();
        logic [15:0] d;
        wr(2'd0, 16'hFFFF);
        @(negedge clk); ext_pin[0] = 1'b1; settle();
        take("R8 rising on pin 0", 16'hFFFA, 1);
        @(negedge clk); ext_pin[0] = 1'b0; settle();
        rd(2'd1, d); check("R8 falling ignored when rising selected", d, 0);
        @(negedge clk); ext_pin[2] = 1'b1; settle();
        rd(2'd1, d); check("R8 rising on pin 2", d, 16'h0200);
        wr(2'd1, 16'h0000);
        wr(2'd2, 16'h0004); settle();
        rd(2'd1, d); check("R10 no side effect when pin high", d, 0);
        @(negedge clk); ext_pin[2] = 1'b0; settle();
        take("R8 falling on pin 2", 16'hFFEA, 1);
        wr(2'd2, 16'h0006); settle();
        rd(2'd1, d); check("R10 polarity flip sets pin 1 request", d, 16'h0004);
        take("R10 pin 1 vector", 16'hFFF8, 1);
        wr(2'd2, 16'h0000); settle();
        wr(2'd1, 16'h0000);
    endtask

    task automatic t_key();
        logic [15:0] d;
        @(negedge clk); key_pin[3] = 1'b0; settle();
        rd(2'd1, d); check("R9 key AND falling sets", d, 16'h1000);
        wr(2'd1, 16'h0000);
        @(negedge clk); key_pin[3] = 1'b1; settle();
        rd(2'd1, d); check("R9 key AND rising ignored", d, 0);
        @(negedge clk); key_pin[0] = 1'b0; settle();
        take("R9 key vector", 16'hFFE0, 1);
        @(negedge clk); key_pin[0] = 1'b1; settle();
    endtask

    task automatic t_shared();
        logic [15:0] d;
        wr(2'd1, 16'h0000);
        wr(2'd2, 16'h0010);
        rd(2'd1, d); check("R11 select change sets slot 13", d, 16'h2000);
        wr(2'd1, 16'h0000);
        @(negedge clk); adc_evt = 1'b1; @(negedge clk); adc_evt = 1'b0;
        rd(2'd1, d); check("R11 unselected event ignored", d, 0);
        @(negedge clk); alt_evt = 1'b1; @(negedge clk); alt_evt = 1'b0;
        rd(2'd1, d); check("R11 selected alternate event", d, 16'h2000);
        wr(2'd1, 16'h0000);
        wr(2'd2, 16'h0010);
        rd(2'd1, d); check("R11 same select no side effect", d, 0);
        wr(2'd2, 16'h0000);
        rd(2'd1, d); check("R11 select back sets slot 13", d, 16'h2000);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        settle();
        t_reset();
        t_sw_access();
        t_set_wins();
        t_mask();
        t_priority();
        t_unmaskable();
        t_edges();
        t_key();
        t_shared();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule